// File: doc/BRIEF.md
# Low-Power Mode Controller with Wake Settling Timer

This block decides how a small processor system idles. It holds one 8-bit control register on a plain write/read register port. When the core reports that its sleep instruction has executed (`sleepReq`), the block moves to one of two idle modes, chosen by the top register bit.

In light sleep, the clock keeps running and any interrupt returns the system to run at once. In deep standby, the clock-enable output is dropped. Only the external wake interrupt can end it. That interrupt starts a down-counter that waits out oscillator settling before the clock is enabled again. The wait length comes from a 3-bit field of the register. The block uses power-of-two lengths, a very short code and a reserved code. The reserved code is handled as the longest wait.

A hardware-standby input holds the register at its initial value and returns the mode to run. Deep standby itself leaves the register untouched.

Top module: `pwr_standby_ctrl`

## Requirements
- R1: The register reads 0x08 after reset. While `hwStandby` is high, it reads 0x08 one cycle later and ignores writes.
- R2: A write (`regWrEn` high) stores all 8 bits of `regWrData`, visible on `regRdData` after the clock edge. Bit 3 reads back as written.
- R3: `modeState` encodes run=0, light sleep=1, deep standby=2, settling=3. `clkEn` is 1 in run and light sleep, and 0 in deep standby and settling.
- R4: In run with register bit 7 = 0, `sleepReq` enters light sleep at the next edge with `clkEn` still 1. An `anyIrq` or `wakeIrq` there returns to run at the next edge.
- R5: In run with bit 7 = 1, `sleepReq` enters deep standby at the next edge.
- R6: In deep standby, `anyIrq` has no effect. Only `wakeIrq` leaves, and it enters settling.
- R7: Settling lasts N cycles and then returns to run. For bits 6:4 = c in 0..5, N = 2^(BASE_LOG2+c) (8192 to 262144 at the default).
- R8: Bits 6:4 = 7 gives a settling length of SHORT_CNT cycles (default 16).
- R9: Bits 6:4 = 6 is reserved and gives the longest length, 2^(BASE_LOG2+5).
- R10: The register keeps its value through deep standby and settling. Bit 7 is still 1 after wake and clears only by a write of 0.
- R11: `hwStandby` during deep standby returns `modeState` to run and the register to 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hwStandby | input | 1 | Hardware standby; forces register to initial value and mode to run |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register contents |
| sleepReq | input | 1 | Sleep instruction executed |
| wakeIrq | input | 1 | External wake interrupt |
| anyIrq | input | 1 | Any other interrupt |
| modeState | output | 2 | Current mode (run, sleep, standby, settling) |
| clkEn | output | 1 | Clock enable for the rest of the system |

## Verification
The hardest situation to reach from the ports is the end of a long settling window for every delay code. The code whose length equals the reserved code's is the hardest of all. At the default sizes those windows span hundreds of thousands of cycles. The bench therefore shrinks `BASE_LOG2` to 3, so the windows run from 8 to 256 cycles. It walks every code through a full sleep, wake and settle sequence, and checks the mode on every cycle of each window. It also asserts hardware standby while the controller sits in deep standby. This covers the priority of the forced reset over the mode machine.

// File: rtl/pwr_standby_pkg.sv
package pwr_standby_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_STANDBY = 2'd2,
    MODE_SETTLE  = 2'd3
  } mode_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } cnt_strobe_t;

  localparam logic [7:0] CTRL_INIT = 8'h08;
  localparam int SEL_BIT = 7;
  localparam int CODE_LSB = 4;
endpackage

// File: rtl/pwr_standby_dp.sv
module pwr_standby_dp
  import pwr_standby_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter int SHORT_CNT = 16,
  localparam int CNT_W = BASE_LOG2 + 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hwStandby,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  input  cnt_strobe_t strobes,
  output logic [7:0]  ctrlReg,
  output logic        standbySel,
  output logic        cntZero
);
  logic [CNT_W-1:0] settleCnt;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W:0]   pow;
  logic [2:0]       delayCode;
  int               shiftAmt;

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctrlReg <= CTRL_INIT;
    else if (hwStandby) ctrlReg <= CTRL_INIT;
    else if (regWrEn)   ctrlReg <= regWrData;
  end

  assign standbySel = ctrlReg[SEL_BIT];
  assign delayCode  = ctrlReg[CODE_LSB+2:CODE_LSB];

  // delay decode: power-of-two table, reserved code clamps to longest
  always_comb begin
    shiftAmt = BASE_LOG2 + ((delayCode == 3'd6) ? 5 : int'(delayCode));
    pow      = {{CNT_W{1'b0}}, 1'b1} << shiftAmt;
    if (delayCode == 3'd7) loadVal = CNT_W'(SHORT_CNT - 1);
    else                   loadVal = CNT_W'(pow - 1'b1);
  end

  // settling down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                settleCnt <= '0;
    else if (strobes.loadCnt) settleCnt <= loadVal;
    else if (strobes.decCnt)  settleCnt <= settleCnt - 1'b1;
  end

  assign cntZero = (settleCnt == '0);
endmodule

// File: rtl/pwr_standby_fsm.sv
module pwr_standby_fsm
  import pwr_standby_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hwStandby,
  input  logic        sleepReq,
  input  logic        wakeIrq,
  input  logic        anyIrq,
  input  logic        standbySel,
  input  logic        cntZero,
  output mode_t       mode,
  output logic        clkEn,
  output cnt_strobe_t strobes
);
  mode_t modeNext;

  always_comb begin
    modeNext        = mode;
    strobes.loadCnt = 1'b0;
    strobes.decCnt  = 1'b0;
    unique case (mode)
      MODE_RUN:
        if (sleepReq) modeNext = standbySel ? MODE_STANDBY : MODE_SLEEP;
      MODE_SLEEP:
        if (anyIrq || wakeIrq) modeNext = MODE_RUN;
      MODE_STANDBY:
        if (wakeIrq) begin
          modeNext        = MODE_SETTLE;
          strobes.loadCnt = 1'b1;
        end
      MODE_SETTLE:
        if (cntZero) modeNext = MODE_RUN;
        else         strobes.decCnt = 1'b1;
      default: modeNext = MODE_RUN;
    endcase
    if (hwStandby) begin
      modeNext        = MODE_RUN;
      strobes.loadCnt = 1'b0;
      strobes.decCnt  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_RUN;
    else       mode <= modeNext;
  end

  assign clkEn = (mode == MODE_RUN) || (mode == MODE_SLEEP);
endmodule

// File: rtl/pwr_standby_ctrl.sv
module pwr_standby_ctrl
  import pwr_standby_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter int SHORT_CNT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwStandby,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sleepReq,
  input  logic       wakeIrq,
  input  logic       anyIrq,
  output logic [1:0] modeState,
  output logic       clkEn
);
  cnt_strobe_t strobes;
  mode_t       mode;
  logic        standbySel;
  logic        cntZero;

  pwr_standby_dp #(.BASE_LOG2(BASE_LOG2), .SHORT_CNT(SHORT_CNT)) u_dp (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby),
    .regWrEn(regWrEn), .regWrData(regWrData), .strobes(strobes),
    .ctrlReg(regRdData), .standbySel(standbySel), .cntZero(cntZero)
  );

  pwr_standby_fsm u_fsm (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby),
    .sleepReq(sleepReq), .wakeIrq(wakeIrq), .anyIrq(anyIrq),
    .standbySel(standbySel), .cntZero(cntZero),
    .mode(mode), .clkEn(clkEn), .strobes(strobes)
  );

  assign modeState = mode;
endmodule

// File: rtl/pwr_standby_chk.sv
module pwr_standby_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hwStandby,
  input logic       regWrEn,
  input logic       sleepReq,
  input logic       wakeIrq,
  input logic       anyIrq,
  input logic [7:0] regRdData,
  input logic [1:0] modeState,
  input logic       clkEn
);
  p_hw_init_r1: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |=> (regRdData == 8'h08));

  p_sleep_clock_r4: assert property (@(posedge clk) disable iff (!rstN || hwStandby)
    (modeState == 2'd0 && sleepReq && !regRdData[7]) |=> (modeState == 2'd1 && clkEn));

  p_standby_entry_r5: assert property (@(posedge clk) disable iff (!rstN || hwStandby)
    (modeState == 2'd0 && sleepReq && regRdData[7]) |=> (modeState == 2'd2 && !clkEn));

  p_standby_hold_r6: assert property (@(posedge clk) disable iff (!rstN || hwStandby)
    (modeState == 2'd2 && !wakeIrq) |=> (modeState == 2'd2));

  p_wake_settle_r6: assert property (@(posedge clk) disable iff (!rstN || hwStandby)
    (modeState == 2'd2 && wakeIrq) |=> (modeState == 2'd3 && !clkEn));

  p_retain_r10: assert property (@(posedge clk) disable iff (!rstN || hwStandby)
    (modeState[1] && !regWrEn) |=> $stable(regRdData));

  p_hw_run_r11: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |=> (modeState == 2'd0));
endmodule

bind pwr_standby_ctrl pwr_standby_chk u_chk (
  .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .regWrEn(regWrEn),
  .sleepReq(sleepReq), .wakeIrq(wakeIrq), .anyIrq(anyIrq),
  .regRdData(regRdData), .modeState(modeState), .clkEn(clkEn)
);

// File: tb/pwr_standby_ctrl_tb.sv
module pwr_standby_ctrl_tb;
  localparam int BASE_LOG2 = 3;
  localparam int SHORT_CNT = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hwStandby = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sleepReq = 1'b0;
  logic       wakeIrq = 1'b0;
  logic       anyIrq = 1'b0;
  logic [1:0] modeState;
  logic       clkEn;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] rd;
    logic [1:0] st;
    string      tag;
  } exp_item_t;
  exp_item_t expQ[$];

  always #5 clk = ~clk;

  pwr_standby_ctrl #(.BASE_LOG2(BASE_LOG2), .SHORT_CNT(SHORT_CNT)) u_dut (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sleepReq(sleepReq),
    .wakeIrq(wakeIrq), .anyIrq(anyIrq), .modeState(modeState), .clkEn(clkEn)
  );

  task automatic compare(input logic [7:0] rd, input logic [1:0] st, input string tag);
    logic ce;
    ce = (st == 2'd0) || (st == 2'd1);
    checks++;
    if (regRdData !== rd || modeState !== st || clkEn !== ce) begin
      errors++;
      $display("FAIL %s: rd=%h mode=%0d clkEn=%b expected rd=%h mode=%0d clkEn=%b",
               tag, regRdData, modeState, clkEn, rd, st, ce);
    end
  endtask

  // monitor: sample 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_item_t it;
        it = expQ.pop_front();
        compare(it.rd, it.st, it.tag);
      end
    end
  end

  // driver: one cycle of stimulus plus the expected result after the edge
  task automatic step(input logic wr, input logic [7:0] d, input logic slp,
                      input logic wk, input logic irq, input logic hw,
                      input logic [7:0] expRd, input logic [1:0] expSt,
                      input string tag);
    exp_item_t it;
    regWrEn = wr; regWrData = d; sleepReq = slp;
    wakeIrq = wk; anyIrq = irq; hwStandby = hw;
    it.rd = expRd; it.st = expSt; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  function automatic int delayOf(input logic [2:0] code);
    if (code == 3'd7) return SHORT_CNT;
    if (code == 3'd6) return 1 << (BASE_LOG2 + 5);
    return 1 << (BASE_LOG2 + int'(code));
  endfunction

  // full standby/wake cycle with a given register value (bit 7 = 1)
  task automatic standbyCycle(input logic [7:0] val, input string tag);
    int n;
    n = delayOf(val[6:4]);
    step(1, val, 0, 0, 0, 0, val, 2'd0, "R2 write");
    step(0, 0, 1, 0, 0, 0, val, 2'd2, "R5 enter standby");
    step(0, 0, 0, 0, 1, 0, val, 2'd2, "R6 anyIrq ignored");
    step(0, 0, 0, 1, 0, 0, val, 2'd3, "R6 wake to settle");
    for (int k = 1; k < n; k++) step(0, 0, 0, 0, 0, 0, val, 2'd3, tag);
    step(0, 0, 0, 0, 0, 0, val, 2'd0, tag);
    step(0, 0, 0, 0, 0, 0, val, 2'd0, "R10 bit7 kept after wake");
  endtask

  initial begin
    @(negedge clk);
    compare(8'h08, 2'd0, "R1 reset value");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare(8'h08, 2'd0, "R1 after reset");

    // R2/R4 light sleep
    step(1, 8'h35, 0, 0, 0, 0, 8'h35, 2'd0, "R2 write all bits");
    step(1, 8'h27, 0, 0, 0, 0, 8'h27, 2'd0, "R2 bit3 cleared/low bits");
    step(0, 0, 1, 0, 0, 0, 8'h27, 2'd1, "R4 enter sleep");
    step(0, 0, 0, 0, 0, 0, 8'h27, 2'd1, "R4 sleep held, R3 clock on");
    step(0, 0, 0, 0, 1, 0, 8'h27, 2'd0, "R4 irq ends sleep");
    step(0, 0, 1, 0, 0, 0, 8'h27, 2'd1, "R4 enter sleep again");
    step(0, 0, 0, 1, 0, 0, 8'h27, 2'd0, "R4 wake irq ends sleep");

    // deep standby for every code
    standbyCycle(8'hF8, "R8 short code settle");
    standbyCycle(8'h80, "R7 code0 settle");
    standbyCycle(8'h91, "R7 code1 settle");
    standbyCycle(8'hA0, "R7 code2 settle");
    standbyCycle(8'hB8, "R7 code3 settle");
    standbyCycle(8'hC2, "R7 code4 settle");
    standbyCycle(8'hD0, "R7 code5 settle");
    standbyCycle(8'hE0, "R9 reserved code longest");

    // R10 only a write of 0 clears bit 7
    step(1, 8'h00, 0, 0, 0, 0, 8'h00, 2'd0, "R10 write clears bit7");
    step(0, 0, 1, 0, 0, 0, 8'h00, 2'd1, "R10 cleared bit selects sleep");
    step(0, 0, 0, 0, 1, 0, 8'h00, 2'd0, "R4 back to run");

    // R11/R1 hardware standby
    step(1, 8'h97, 0, 0, 0, 0, 8'h97, 2'd0, "R2 write");
    step(0, 0, 1, 0, 0, 0, 8'h97, 2'd2, "R5 enter standby");
    step(0, 0, 0, 0, 0, 1, 8'h08, 2'd0, "R11 hw standby forces run/init");
    step(1, 8'hC5, 0, 0, 0, 1, 8'h08, 2'd0, "R1 write ignored under hw standby");
    step(0, 0, 0, 0, 0, 0, 8'h08, 2'd0, "R1 value after hw standby");
    step(1, 8'h9C, 0, 0, 0, 0, 8'h9C, 2'd0, "R2 write after hw standby");
    step(0, 0, 1, 0, 0, 0, 8'h9C, 2'd2, "R5 standby");
    step(0, 0, 0, 1, 0, 1, 8'h08, 2'd0, "R11 hw standby beats wake");
    step(0, 0, 0, 0, 0, 0, 8'h08, 2'd0, "R11 stays run");

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule